// File: doc/BRIEF.md
# Page Check-Symbol Generator

This block computes a four-symbol Reed-Solomon check word over one 512-byte page while the page streams through it one byte per accepted cycle. The same hardware serves both directions of traffic. When a page is written to storage, the block hands back a 6-byte signature that is stored beside the data. When a page is read back, the stored signature follows the data on the same byte port, and the block reports whether the recomputed check word matches it.

The byte stream is cut into 10-bit symbols over GF(2^10). Four check symbols allow later software to correct up to two bad symbols, so the hardware only has to detect errors. Error location and correction are handled outside the block. A start pulse opens each page, fixes the direction for that page and clears all running state.

Top module: `rs_page_sig`

## Requirements
- R1: While reset is active, and after it is released until the first start, `sig_o` is zero and `err_o` and `done_o` are low.
- R2: A `start_i` pulse clears the check symbols, the byte position and `err_o`, and latches `rd_i` as the page direction. A byte presented with `vld_i` in the same cycle as `start_i` is not absorbed.
- R3: Data stream bit n is bit n mod 8 of page byte n/8. Symbol k takes stream bits 10k to 10k+9, with bit 10k as its LSB. The last symbol carries the page's final 6 bits in its low positions, and its upper 4 bits are zero.
- R4: The check word is the remainder of m(x)·x^4 divided by g(x) = (x+α)(x+α²)(x+α³)(x+α⁴). Here m(x) has symbol 0 as its highest-degree coefficient, and the field uses x^10+x^3+1 with α = x (value 2).
- R5: `sig_o[10k+9:10k]` holds the remainder coefficient of x^k (k = 0..3), and `sig_o[47:40]` is zero. Signature byte j is `sig_o[8j+7:8j]`.
- R6: In write mode, `done_o` is high for exactly one cycle. It rises at the second clock edge after the edge that accepts byte 511, and `err_o` stays low.
- R7: In read mode, the 6 stored signature bytes follow byte 511 on `byte_i`, byte j first for j = 0..5. `done_o` rises for one cycle at the second edge after the edge that accepts stored byte 5. `err_o` is then high exactly when any of the 48 stored bits differs from the recomputed `sig_o`.
- R8: A read of a page with 1 to 4 flipped data bits, checked against the signature of the clean page, sets `err_o`.
- R9: Bytes offered after the page's last byte have no effect on `sig_o`, `err_o` or `done_o` until the next start.
- R10: Idle cycles between accepted bytes do not change `sig_o`, `err_o`, or when `done_o` rises relative to the last accepted byte.
- R11: A start in the middle of a page discards every byte absorbed before it.
- R12: `err_o` changes only in the cycle in which `done_o` is high or in the cycle after a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Page start pulse |
| rd_i | input | 1 | Direction sampled at start: 1 read/check, 0 write/generate |
| vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Page data byte, then stored signature bytes on a read |
| sig_o | output | 48 | Computed signature, zero-extended check word |
| err_o | output | 1 | Signature mismatch, valid from done until next start |
| done_o | output | 1 | One-cycle end-of-page pulse |

## Verification
The check word and the mismatch flag are both due at one exact cycle. `done_o` and the final `sig_o` appear after the second rising edge that follows the accepting edge of the page's last byte. That last byte is data byte 511 on a write and stored byte 5 on a read, and the extra edge absorbs the zero-padded last symbol or performs the comparison. The bench drives and samples on falling edges. It checks `done_o`, `sig_o` and `err_o` at the falling edge after that second edge, and checks that `done_o` is low again one cycle later. Effects of a start are checked at the first falling edge after the start edge.

// File: rtl/rs_sig_pkg.sv
package rs_sig_pkg;
  localparam int SYM_W = 10;
  // x^10 + x^3 + 1 with the x^10 term implied
  localparam logic [SYM_W-1:0] PRIM_LOW = 10'h009;

  typedef logic [SYM_W-1:0] sym_t;

  function automatic sym_t gf_mul(input sym_t a, input sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[SYM_W-2:0], 1'b0} ^ (sh[SYM_W-1] ? PRIM_LOW : '0);
    end
    return acc;
  endfunction

  function automatic sym_t gf_alpha_pow(input int n);
    sym_t r;
    r = sym_t'(1);
    for (int i = 0; i < n; i++) r = gf_mul(r, sym_t'(2));
    return r;
  endfunction
endpackage

// File: rtl/rs_sym_pack.sv
module rs_sym_pack
  import rs_sig_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              flush_i,
  output logic              sym_vld_o,
  output sym_t              sym_o
);
  localparam int ACC_W  = SYM_W - 1 + BYTE_W;
  localparam int FILL_W = $clog2(ACC_W + 1);

  logic [ACC_W-1:0]  acc_q, acc_d, merged;
  logic [FILL_W-1:0] fill_q, fill_d, fill_sum;

  always_comb begin
    merged   = acc_q | (ACC_W'(byte_i) << fill_q);
    fill_sum = fill_q + FILL_W'(BYTE_W);
    acc_d     = acc_q;
    fill_d    = fill_q;
    sym_vld_o = 1'b0;
    sym_o     = acc_q[SYM_W-1:0];
    if (clr_i) begin
      acc_d  = '0;
      fill_d = '0;
    end else if (flush_i) begin
      sym_vld_o = (fill_q != '0);
      acc_d     = '0;
      fill_d    = '0;
    end else if (byte_vld_i) begin
      if (fill_sum >= FILL_W'(SYM_W)) begin
        sym_vld_o = 1'b1;
        sym_o     = merged[SYM_W-1:0];
        acc_d     = merged >> SYM_W;
        fill_d    = fill_sum - FILL_W'(SYM_W);
      end else begin
        acc_d  = merged;
        fill_d = fill_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      fill_q <= '0;
    end else begin
      acc_q  <= acc_d;
      fill_q <= fill_d;
    end
  end
endmodule

// File: rtl/rs_par_lfsr.sv
module rs_par_lfsr
  import rs_sig_pkg::*;
#(
  parameter int NPAR = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  sym_vld_i,
  input  sym_t                  sym_i,
  output logic [NPAR*SYM_W-1:0] par_o
);
  function automatic logic [NPAR:0][SYM_W-1:0] build_gen();
    logic [NPAR:0][SYM_W-1:0] g;
    sym_t root;
    g    = '0;
    g[0] = sym_t'(1);
    for (int i = 1; i <= NPAR; i++) begin
      root = gf_alpha_pow(i);
      for (int j = i; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
      g[0] = gf_mul(g[0], root);
    end
    return g;
  endfunction

  localparam logic [NPAR:0][SYM_W-1:0] GEN = build_gen();

  logic [NPAR-1:0][SYM_W-1:0] par_q, par_d, par_sh;
  sym_t fb;

  assign fb = sym_i ^ par_q[NPAR-1];

  for (genvar k = 0; k < NPAR; k++) begin : g_stage
    if (k == 0) begin : g_low
      assign par_sh[k] = gf_mul(fb, GEN[k]);
    end else begin : g_mid
      assign par_sh[k] = par_q[k-1] ^ gf_mul(fb, GEN[k]);
    end
  end

  always_comb begin
    if (clr_i)          par_d = '0;
    else if (sym_vld_i) par_d = par_sh;
    else                par_d = par_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_q <= '0;
    else        par_q <= par_d;
  end

  assign par_o = par_q;
endmodule

// File: rtl/rs_page_sig.sv
module rs_page_sig
  import rs_sig_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  parameter int NPAR       = 4,
  parameter int SIG_BYTES  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   rd_i,
  input  logic                   vld_i,
  input  logic [7:0]             byte_i,
  output logic [SIG_BYTES*8-1:0] sig_o,
  output logic                   err_o,
  output logic                   done_o
);
  localparam int PAR_W    = NPAR * SYM_W;
  localparam int SIG_W    = SIG_BYTES * 8;
  localparam int PAD_BITS = (PAGE_BYTES * 8) % SYM_W;
  localparam int XFER_MAX = PAGE_BYTES + SIG_BYTES;
  localparam int CNT_W    = $clog2(XFER_MAX + 1);
  localparam int SIDX_W   = (SIG_BYTES > 1) ? $clog2(SIG_BYTES) : 1;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             rd_q, rd_d;
  logic             last_q, last_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic [SIG_BYTES-1:0][7:0] stored_q, stored_d;
  logic             take, take_data, take_sig, flush_req, flush_w;
  logic [SIDX_W-1:0] sidx;
  logic             sym_vld;
  sym_t             sym;
  logic [PAR_W-1:0] par;
  logic [SIG_W-1:0] sig_full;

  assign sig_full = SIG_W'(par);

  always_comb begin
    limit     = rd_q ? CNT_W'(XFER_MAX) : CNT_W'(PAGE_BYTES);
    take      = vld_i && !start_i && (cnt_q < limit);
    take_data = take && (cnt_q < CNT_W'(PAGE_BYTES));
    take_sig  = take && !take_data;
    flush_req = !start_i && take_data && (cnt_q == CNT_W'(PAGE_BYTES - 1));
    sidx      = SIDX_W'(cnt_q - CNT_W'(PAGE_BYTES));

    cnt_d  = start_i ? '0 : (take ? cnt_q + CNT_W'(1) : cnt_q);
    rd_d   = start_i ? rd_i : rd_q;
    last_d = !start_i && take && (cnt_q == limit - CNT_W'(1));
    done_d = !start_i && last_q;

    if (start_i)     err_d = 1'b0;
    else if (last_q) err_d = rd_q && (stored_q != sig_full);
    else             err_d = err_q;

    stored_d = stored_q;
    if (start_i) begin
      stored_d = '0;
    end else if (take_sig) begin
      for (int j = 0; j < SIG_BYTES; j++)
        if (sidx == SIDX_W'(j)) stored_d[j] = byte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cnt_q    <= '0;
      rd_q     <= 1'b0;
      last_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      stored_q <= '0;
    end else begin
      cnt_q    <= cnt_d;
      rd_q     <= rd_d;
      last_q   <= last_d;
      done_q   <= done_d;
      err_q    <= err_d;
      stored_q <= stored_d;
    end
  end

  // an extra symbol slot exists only when the page does not end on a symbol boundary
  if (PAD_BITS != 0) begin : g_pad
    logic flush_q;
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) flush_q <= 1'b0;
      else          flush_q <= flush_req;
    end
    assign flush_w = flush_q && !start_i;
  end else begin : g_nopad
    assign flush_w = 1'b0;
  end

  rs_sym_pack #(.BYTE_W(8)) u_pack (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .clr_i      (start_i),
    .byte_vld_i (take_data),
    .byte_i     (byte_i),
    .flush_i    (flush_w),
    .sym_vld_o  (sym_vld),
    .sym_o      (sym)
  );

  rs_par_lfsr #(.NPAR(NPAR)) u_lfsr (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .clr_i     (start_i),
    .sym_vld_i (sym_vld),
    .sym_i     (sym),
    .par_o     (par)
  );

  assign sig_o  = sig_full;
  assign err_o  = err_q;
  assign done_o = done_q;
endmodule

// File: rtl/rs_page_sig_chk.sv
module rs_page_sig_chk #(
  parameter int SIG_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             done_i,
  input logic             err_i,
  input logic [SIG_W-1:0] sig_i,
  input logic             rd_mode_i
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !done_i); // R6

  AST_WRITE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !rd_mode_i) |-> !err_i); // R6

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (sig_i == '0) && !err_i && !done_i); // R2

  AST_SIG_HELD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !start_i) |=> $stable(sig_i)); // R9

  AST_ERR_CHANGE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_i) |-> (done_i || $past(start_i))); // R12
endmodule

bind rs_page_sig rs_page_sig_chk #(.SIG_W(SIG_BYTES*8)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .start_i   (start_i),
  .done_i    (done_o),
  .err_i     (err_o),
  .sig_i     (sig_o),
  .rd_mode_i (rd_q)
);

// File: tb/rs_page_sig_tb_top.sv
module rs_page_sig_tb_top;
  typedef logic [7:0] page_t [512];

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        rd_i = 1'b0;
  logic        vld_i = 1'b0;
  logic [7:0]  byte_i = 8'h00;
  logic [47:0] sig_o;
  logic        err_o;
  logic        done_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  rs_page_sig dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i), .vld_i(vld_i),
    .byte_i(byte_i), .sig_o(sig_o), .err_o(err_o), .done_o(done_o)
  );

  // {kind[3:0], rd, nflip[2:0], seed[15:0]}
  // kind 0 zeros, 1 all ones, 2 counting, 3 pseudo-random, 4 only top bit of byte 511
  localparam logic [23:0] VEC [10] = '{
    24'h000000, 24'h100000, 24'h200000, 24'h30ACE1, 24'h381234,
    24'h391234, 24'h2A0005, 24'h1B004D, 24'h3C5A5A, 24'h4001FF
  };

  logic [9:0] gcoef [5];

  function automatic logic [9:0] bmul(input logic [9:0] a, input logic [9:0] b);
    logic [10:0] x;
    logic [9:0]  r;
    x = {1'b0, a};
    r = '0;
    for (int i = 0; i < 10; i++) begin
      if (b[i]) r = r ^ x[9:0];
      x = x << 1;
      if (x[10]) x = x ^ 11'h409;
    end
    return r;
  endfunction

  // long division of the zero-extended message by the monic generator
  function automatic logic [47:0] model_sig(input page_t p);
    logic [9:0] w [414];
    logic [9:0] c;
    int n;
    for (int k = 0; k < 414; k++) w[k] = '0;
    for (int k = 0; k < 410; k++)
      for (int b = 0; b < 10; b++) begin
        n = 10 * k + b;
        if (n < 4096) w[k][b] = p[n / 8][n % 8];
      end
    for (int i = 0; i < 410; i++) begin
      c = w[i];
      for (int j = 1; j <= 4; j++) w[i + j] = w[i + j] ^ bmul(c, gcoef[4 - j]);
    end
    return {8'h00, w[410], w[411], w[412], w[413]};
  endfunction

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    vld_i = 1'b1;
    byte_i = b;
    @(negedge clk);
  endtask

  task automatic idle();
    vld_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_start(input logic rd);
    start_i = 1'b1;
    rd_i = rd;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send_page(input page_t p, input bit gaps);
    for (int i = 0; i < 512; i++) begin
      put(p[i]);
      if (gaps) idle();
    end
  endtask

  task automatic send_sig(input logic [47:0] s);
    for (int j = 0; j < 6; j++) put(s[8*j +: 8]);
  endtask

  function automatic page_t make_page(input logic [3:0] kind, input logic [15:0] seed);
    page_t p;
    logic [15:0] x;
    x = (seed == 16'h0) ? 16'h1 : seed;
    for (int i = 0; i < 512; i++) begin
      x = x ^ (x << 7);
      x = x ^ (x >> 9);
      x = x ^ (x << 8);
      case (kind)
        4'd0: p[i] = 8'h00;
        4'd1: p[i] = 8'hFF;
        4'd2: p[i] = i[7:0];
        4'd3: p[i] = x[7:0];
        default: p[i] = (i == 511) ? 8'h80 : 8'h00;
      endcase
    end
    return p;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    page_t clean, sent;
    logic [47:0] exp_sig, bad;
    logic [3:0] kind;
    logic rd;
    int nflip, seed, pos;

    // generator (x+a)(x+a^2)(x+a^3)(x+a^4), built from the roots
    begin
      logic [9:0] rt;
      for (int i = 0; i < 5; i++) gcoef[i] = '0;
      gcoef[0] = 10'd1;
      rt = 10'd1;
      for (int i = 1; i <= 4; i++) begin
        rt = bmul(rt, 10'd2);
        for (int j = i; j >= 1; j--) gcoef[j] = gcoef[j-1] ^ bmul(gcoef[j], rt);
        gcoef[0] = bmul(gcoef[0], rt);
      end
    end

    repeat (3) @(negedge clk);
    chk("R1 sig in reset", sig_o, 48'h0);
    chk("R1 err/done in reset", {46'h0, err_o, done_o}, 48'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {sig_o[45:0], err_o, done_o}, 48'h0);

    // table walk
    for (int v = 0; v < 10; v++) begin
      kind  = VEC[v][23:20];
      rd    = VEC[v][19];
      nflip = int'(VEC[v][18:16]);
      seed  = int'(VEC[v][15:0]);
      clean = make_page(kind, VEC[v][15:0]);
      sent  = clean;
      for (int i = 0; i < nflip; i++) begin
        pos = (seed * 37 + i * 1021) % 4096;
        sent[pos / 8][pos % 8] = ~sent[pos / 8][pos % 8];
      end
      exp_sig = model_sig(clean);
      pulse_start(rd);
      send_page(sent, 1'b0);
      if (rd) send_sig(exp_sig);
      idle();
      chk("R6 R7 done due", {47'h0, done_o}, 48'h1);
      chk("R3 R4 R5 signature", sig_o, model_sig(sent));
      chk("R7 R8 error flag", {47'h0, err_o}, {47'h0, (rd && nflip != 0)});
      idle();
      chk("R6 done one cycle", {47'h0, done_o}, 48'h0);
    end

    // R2: byte with vld in the start cycle is dropped
    clean = make_page(4'd0, 16'h0);
    start_i = 1'b1; rd_i = 1'b0; vld_i = 1'b1; byte_i = 8'hFF;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 cleared after start", {sig_o[46:0], done_o}, 48'h0);
    send_page(clean, 1'b0);
    idle();
    chk("R2 start-cycle byte ignored, done", {47'h0, done_o}, 48'h1);
    chk("R2 start-cycle byte ignored, sig", sig_o, 48'h0);

    // R9: extra bytes after the page
    clean = make_page(4'd2, 16'h0);
    exp_sig = model_sig(clean);
    pulse_start(1'b0);
    send_page(clean, 1'b0);
    idle();
    for (int i = 0; i < 8; i++) put(8'hA5);
    idle();
    chk("R9 sig after extra bytes", sig_o, exp_sig);
    chk("R9 no done/err after extra bytes", {46'h0, err_o, done_o}, 48'h0);

    // R10: idle cycles between bytes
    clean = make_page(4'd3, 16'h7777);
    pulse_start(1'b0);
    send_page(clean, 1'b1);
    chk("R10 done timing with gaps", {47'h0, done_o}, 48'h1);
    chk("R10 sig with gaps", sig_o, model_sig(clean));

    // R11: restart mid-page
    clean = make_page(4'd3, 16'h4321);
    pulse_start(1'b0);
    for (int i = 0; i < 100; i++) put(8'hFF);
    idle();
    pulse_start(1'b0);
    send_page(clean, 1'b0);
    idle();
    chk("R11 restart discards partial page", sig_o, model_sig(clean));

    // R7 R12: corrupt top stored byte, hold, then clear on start
    clean = make_page(4'd3, 16'h2468);
    exp_sig = model_sig(clean);
    bad = exp_sig;
    bad[40] = 1'b1;
    pulse_start(1'b1);
    send_page(clean, 1'b0);
    send_sig(bad);
    idle();
    chk("R7 stored top byte mismatch", {46'h0, err_o, done_o}, 48'h3);
    repeat (3) idle();
    chk("R12 err held", {47'h0, err_o}, 48'h1);
    pulse_start(1'b1);
    chk("R12 R2 err cleared by start", {47'h0, err_o}, 48'h0);

    // R7: one flipped bit in stored byte 0
    bad = exp_sig;
    bad[3] = ~bad[3];
    send_page(clean, 1'b0);
    send_sig(bad);
    idle();
    chk("R7 stored byte 0 mismatch", {46'h0, err_o, done_o}, 48'h3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule